// File: doc/BRIEF.md
# SMBus Host Descriptor Ring Scheduler

This block sequences the work of an SMBus host controller through a small circular ring of transaction descriptors. Software owns a head pointer in the control word and the block owns a tail pointer in the status word. Every slot between the tail and the head is pending work. While the run bit is set, the scheduler offers the slot at the tail to a downstream bus sequencer. It waits for that sequencer to report the outcome and writes the returned status back against the slot. It then moves the tail forward, wrapping to zero after the last slot.

The sequencer fetches each descriptor and returns its control byte together with the status. The scheduler needs two bits of that control byte. One asks for a completion interrupt. The other stops the ring when the transfer fails. Two sticky interrupt causes, completion and error, are cleared by writing ones. The interrupt line is their OR. The ring length is programmed as the number of slots minus one.

To submit work, software advances the head by one modulo the ring length and sets the run bit. It may also advance the head by several slots at once to queue a batch.

Top module: `smb_ring_sched`

## Requirements
- R1: After reset every register reads zero, `issue_valid` is low and `irq` is low.
- R2: The control word is at offset 0x0. Bit 0 is the run bit, bit 4 is the error-interrupt enable, and bits 23:16 are the software head. Other bits read as zero. The whole word reads back as written.
- R3: The ring length word is at offset 0x8. Only bits 7:0 are kept, and they hold the slot count minus one. The tail wraps to 0 after completing the slot whose index equals that value.
- R4: When the run bit is set and the tail differs from the head, `issue_valid` rises with `issue_idx` equal to the tail. Both hold steady until `issue_ready` is seen.
- R5: A `done_valid` pulse is accepted only while a handed-off slot is outstanding. An accepted pulse produces `wb_valid` in the same cycle, with `wb_idx` set to the tail and `wb_status` set to `done_status`, and advances the tail by one. A pulse at any other time changes nothing.
- R6: The status word is at offset 0x4. Bit 0 is the in-progress flag, bit 4 is the error cause, bit 5 is the completion cause, and bits 23:16 are the tail. The in-progress flag is high from hand-off until the tail reaches the head, processing halts, or the run bit stops the ring.
- R7: The completion cause is set by an accepted completion only when bit 6 of `done_ctrl` is 1.
- R8: The error cause is set by an accepted completion only when the error enable is 1 and bit 0 of `done_status` (success) is 0.
- R9: Writing 1 to status bit 4 or 5 clears that cause. Writing 0 has no effect. A new cause arriving in the same cycle as the clear wins.
- R10: `irq` is high exactly when at least one cause bit is set.
- R11: A failed completion (status bit 0 low) whose `done_ctrl` bit 7 is 1 is still written back, and the tail still advances. The ring then halts: nothing more is handed off until the run bit has been written to 0 and then set again.
- R12: Clearing the run bit while a slot is outstanding lets that slot complete. After that, nothing new is handed off and the head is left untouched.
- R13: Several pending slots are handed off back to back in ring order, including across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| issue_valid | output | 1 | A slot is offered to the sequencer |
| issue_ready | input | 1 | Sequencer takes the offered slot |
| issue_idx | output | 8 | Ring index of the offered slot |
| done_valid | input | 1 | Sequencer reports the outcome of the outstanding slot |
| done_status | input | 8 | Outcome byte, bit 0 = success |
| done_ctrl | input | 8 | Control byte of the finished descriptor (bit 6 interrupt request, bit 7 stop on failure) |
| wb_valid | output | 1 | Status write-back strobe |
| wb_idx | output | 8 | Slot index being written back |
| wb_status | output | 8 | Status byte being written back |
| irq | output | 1 | Interrupt, OR of the cause bits |

## Verification
The hardest state to reach from the ports is a halt that strands pending work. The bench queues two slots and fails the first one with the stop bit set. It then confirms at the ports that the second slot is never offered, even though the run bit is still 1. It releases the halt only through a clear-then-set of the run bit.

A second difficult case is clearing the run bit in the narrow window while a slot is outstanding. The bench splits hand-off and completion into separate steps so that it can write the control word between them.

Ring lengths of one to four slots are each swept around the ring more than twice. Successes and failures alternate during the sweep, so every wrap point and both cause bits are exercised.

// File: rtl/smb_ring_pkg.sv
package smb_ring_pkg;

    localparam int DATA_W = 32;
    localparam int PTR_W  = 8;
    localparam int BYTE_W = 8;

    // register byte offsets
    localparam int OFF_CTRL = 'h0;
    localparam int OFF_STAT = 'h4;
    localparam int OFF_SIZE = 'h8;

    // field positions
    localparam int CTL_RUN   = 0;
    localparam int CTL_ERREN = 4;
    localparam int PTR_LSB   = 16;
    localparam int STS_BUSY  = 0;
    localparam int STS_ERR   = 4;
    localparam int STS_CMP   = 5;

    // descriptor control / status bit positions
    localparam int DSC_OK  = 0;
    localparam int DSC_IRQ = 6;
    localparam int DSC_SOE = 7;

    typedef logic [PTR_W-1:0] ptr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_HALT
    } ring_state_e;

    typedef struct packed {
        logic run;
        logic err_en;
        ptr_t head;
        ptr_t size_m1;
    } ring_cfg_t;

    typedef struct packed {
        logic              valid;
        ptr_t              idx;
        logic [BYTE_W-1:0] status;
        logic [BYTE_W-1:0] ctrl;
    } ring_cpl_t;

    function automatic ptr_t ptr_step(input ptr_t p, input ptr_t last);
        return (p >= last) ? '0 : p + ptr_t'(1);
    endfunction

endpackage

// File: rtl/smb_ring_regs.sv
module smb_ring_regs
    import smb_ring_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  ptr_t              tail,
    input  logic              busy,
    input  ring_cpl_t         cpl,
    output ring_cfg_t         cfg,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_SIZE = ADDR_W'(OFF_SIZE);

    logic cause_err, cause_cmp;
    logic set_err, set_cmp, clr_err, clr_cmp;

    assign set_cmp = cpl.valid && cpl.ctrl[DSC_IRQ];
    assign set_err = cpl.valid && !cpl.status[DSC_OK] && cfg.err_en;
    assign clr_cmp = reg_wr && (reg_addr == A_STAT) && reg_wdata[STS_CMP];
    assign clr_err = reg_wr && (reg_addr == A_STAT) && reg_wdata[STS_ERR];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            cause_err <= 1'b0;
            cause_cmp <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_CTRL) begin
                cfg.run    <= reg_wdata[CTL_RUN];
                cfg.err_en <= reg_wdata[CTL_ERREN];
                cfg.head   <= reg_wdata[PTR_LSB +: PTR_W];
            end
            if (reg_wr && reg_addr == A_SIZE)
                cfg.size_m1 <= reg_wdata[PTR_W-1:0];
            cause_cmp <= set_cmp || (cause_cmp && !clr_cmp);
            cause_err <= set_err || (cause_err && !clr_err);
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[CTL_RUN]              = cfg.run;
                reg_rdata[CTL_ERREN]            = cfg.err_en;
                reg_rdata[PTR_LSB +: PTR_W]     = cfg.head;
            end
            A_STAT: begin
                reg_rdata[STS_BUSY]             = busy;
                reg_rdata[STS_ERR]              = cause_err;
                reg_rdata[STS_CMP]              = cause_cmp;
                reg_rdata[PTR_LSB +: PTR_W]     = tail;
            end
            A_SIZE:  reg_rdata[PTR_W-1:0]       = cfg.size_m1;
            default: reg_rdata                  = '0;
        endcase
    end

    assign irq = cause_err || cause_cmp;

endmodule

// File: rtl/smb_ring_fsm.sv
module smb_ring_fsm
    import smb_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ring_cfg_t         cfg,
    input  logic              issue_ready,
    input  logic              done_valid,
    input  logic [BYTE_W-1:0] done_status,
    input  logic [BYTE_W-1:0] done_ctrl,
    output logic              issue_valid,
    output ptr_t              issue_idx,
    output ring_cpl_t         cpl,
    output ptr_t              tail,
    output logic              busy
);

    ring_state_e state, state_nx;
    ptr_t        tail_nx;
    logic        accept, halt_now;

    assign accept   = (state == ST_WAIT) && done_valid;
    assign halt_now = done_ctrl[DSC_SOE] && !done_status[DSC_OK];
    assign tail_nx  = ptr_step(tail, cfg.size_m1);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cfg.run && tail != cfg.head) state_nx = ST_ISSUE;
            ST_ISSUE: if (issue_ready) state_nx = ST_WAIT;
            ST_WAIT: begin
                if (done_valid) begin
                    if (halt_now)                              state_nx = ST_HALT;
                    else if (cfg.run && tail_nx != cfg.head)   state_nx = ST_ISSUE;
                    else                                       state_nx = ST_IDLE;
                end
            end
            ST_HALT:  if (!cfg.run) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            tail  <= '0;
        end else begin
            state <= state_nx;
            if (accept) tail <= tail_nx;
        end
    end

    assign issue_valid = (state == ST_ISSUE);
    assign issue_idx   = tail;
    assign busy        = (state == ST_ISSUE) || (state == ST_WAIT);

    always_comb begin
        cpl.valid  = accept;
        cpl.idx    = tail;
        cpl.status = done_status;
        cpl.ctrl   = done_ctrl;
    end

endmodule

// File: rtl/smb_ring_sched.sv
module smb_ring_sched
    import smb_ring_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              issue_valid,
    input  logic              issue_ready,
    output logic [7:0]        issue_idx,
    input  logic              done_valid,
    input  logic [7:0]        done_status,
    input  logic [7:0]        done_ctrl,
    output logic              wb_valid,
    output logic [7:0]        wb_idx,
    output logic [7:0]        wb_status,
    output logic              irq
);

    ring_cfg_t cfg;
    ring_cpl_t cpl;
    ptr_t      tail_ptr;
    logic      busy;

    smb_ring_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tail      (tail_ptr),
        .busy      (busy),
        .cpl       (cpl),
        .cfg       (cfg),
        .irq       (irq)
    );

    smb_ring_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .issue_ready (issue_ready),
        .done_valid  (done_valid),
        .done_status (done_status),
        .done_ctrl   (done_ctrl),
        .issue_valid (issue_valid),
        .issue_idx   (issue_idx),
        .cpl         (cpl),
        .tail        (tail_ptr),
        .busy        (busy)
    );

    assign wb_valid  = cpl.valid;
    assign wb_idx    = cpl.idx;
    assign wb_status = cpl.status;

endmodule

// File: rtl/smb_ring_sched_chk.sv
module smb_ring_sched_chk (
    input logic       clk,
    input logic       rst,
    input logic       issue_valid,
    input logic       issue_ready,
    input logic [7:0] issue_idx,
    input logic       wb_valid,
    input logic [7:0] tail,
    input logic [7:0] size_m1,
    input logic       busy,
    input logic       run,
    input logic       irq
);

    // R4
    offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        issue_valid && !issue_ready |=> issue_valid && $stable(issue_idx));

    // R5
    tail_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wb_valid |=> $stable(tail));

    // R5
    tail_step_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid && tail < size_m1 |=> tail == $past(tail) + 8'd1);

    // R3
    tail_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid && tail == size_m1 |=> tail == 8'd0);

    // R6
    wb_busy_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> busy);

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(wb_valid));

    // R12
    run_off_chk: assert property (@(posedge clk) disable iff (rst)
        !run && !busy |=> !issue_valid);

endmodule

bind smb_ring_sched smb_ring_sched_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .issue_ready (issue_ready),
    .issue_idx   (issue_idx),
    .wb_valid    (wb_valid),
    .tail        (tail_ptr),
    .size_m1     (cfg.size_m1),
    .busy        (busy),
    .run         (cfg.run),
    .irq         (irq)
);

// File: tb/test_smb_ring_sched.sv
module test_smb_ring_sched;

    localparam int ADDR_W = 4;
    localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_SIZE = 4'h8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        issue_valid, issue_ready = 1'b0;
    logic [7:0]  issue_idx;
    logic        done_valid = 1'b0;
    logic [7:0]  done_status = '0, done_ctrl = '0;
    logic        wb_valid;
    logic [7:0]  wb_idx, wb_status;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // 100 MHz: 10 time units per period
    always #5 clk = ~clk;

    smb_ring_sched #(.ADDR_W(ADDR_W)) i_smb_ring_sched (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_idx(issue_idx),
        .done_valid(done_valid), .done_status(done_status), .done_ctrl(done_ctrl),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_status(wb_status), .irq(irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input logic [7:0] head, input logic en, input logic run);
        return {8'h0, head, 11'h0, en, 3'h0, run};
    endfunction

    function automatic logic [31:0] mk_stat(input logic [7:0] tail, input logic cmp, input logic err, input logic bsy);
        return {8'h0, tail, 10'h0, cmp, err, 3'h0, bsy};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_issue(input string tag, input logic [7:0] exp_idx);
        int n = 0;
        while (!issue_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " issue_valid"}, {31'h0, issue_valid}, 32'h1);
        chk({tag, " issue_idx"}, {24'h0, issue_idx}, {24'h0, exp_idx});
    endtask

    task automatic give_ready(input int hold);
        logic [31:0] s;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk("R4 offer held", {31'h0, issue_valid}, 32'h1);
        end
        issue_ready = 1'b1;
        @(negedge clk);
        issue_ready = 1'b0;
        peek(A_STAT, s);
        chk("R6 busy while outstanding", {31'h0, s[0]}, 32'h1);
    endtask

    task automatic give_done(input string tag, input logic [7:0] exp_idx,
                             input logic [7:0] st, input logic [7:0] ct);
        done_valid = 1'b1; done_status = st; done_ctrl = ct;
        #1;
        chk({tag, " wb_valid"}, {31'h0, wb_valid}, 32'h1);
        chk({tag, " wb_idx"}, {24'h0, wb_idx}, {24'h0, exp_idx});
        chk({tag, " wb_status"}, {24'h0, wb_status}, {24'h0, st});
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic serve(input string tag, input logic [7:0] idx, input logic [7:0] st,
                         input logic [7:0] ct, input int hold);
        wait_issue(tag, idx);
        give_ready(hold);
        give_done(tag, idx, st, ct);
    endtask

    task automatic no_issue(input string tag, input int n);
        logic seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (issue_valid) seen = 1'b1;
        end
        chk(tag, {31'h0, seen}, 32'h0);
    endtask

    initial begin
        logic [31:0] d;
        logic [7:0]  head, tail;

        do_reset();
        // R1 reset state
        peek(A_CTRL, d); chk("R1 ctrl after reset", d, 0);
        peek(A_STAT, d); chk("R1 stat after reset", d, 0);
        peek(A_SIZE, d); chk("R1 size after reset", d, 0);
        chk("R1 issue_valid after reset", {31'h0, issue_valid}, 0);
        chk("R1 irq after reset", {31'h0, irq}, 0);

        // R2 control layout and readback (run off so nothing starts)
        wr(A_CTRL, 32'h00AB_0010);
        peek(A_CTRL, d); chk("R2 ctrl readback", d, 32'h00AB_0010);
        wr(A_CTRL, 32'hFF00_FFEE);
        peek(A_CTRL, d); chk("R2 ctrl unused bits", d, 32'h0);
        // R3 size keeps low byte only
        wr(A_SIZE, 32'hFFFF_FF05);
        peek(A_SIZE, d); chk("R3 size readback", d, 32'h5);

        // Sweep ring lengths 1..4, alternating success/failure (R3 R5 R6 R7 R8 R9 R10)
        for (int n = 1; n <= 4; n++) begin
            do_reset();
            wr(A_SIZE, n - 1);
            head = 0; tail = 0;
            if (n == 1) begin
                wr(A_CTRL, mk_ctrl(8'h0, 1'b1, 1'b1));
                no_issue("R4 one-slot ring never pending", 6);
                peek(A_STAT, d); chk("R3 one-slot tail", d, 0);
            end else begin
                for (int k = 0; k < 2 * n + 1; k++) begin
                    logic ok;
                    ok = (k % 2) == 0;
                    head = (head + 1) % n;
                    wr(A_CTRL, mk_ctrl(head, 1'b1, 1'b1));
                    serve("R5 sweep", tail, ok ? 8'h01 : 8'h08, ok ? 8'h40 : 8'h00, k % 3);
                    tail = (tail + 1) % n;
                    peek(A_STAT, d);
                    chk("R3 R6 R7 R8 stat after completion", d, mk_stat(tail, ok, !ok, 1'b0));
                    chk("R10 irq on cause", {31'h0, irq}, 1);
                    if (!ok && k == 1) begin
                        wr(A_STAT, 32'h0);
                        peek(A_STAT, d); chk("R9 write zero keeps cause", {31'h0, d[4]}, 1);
                    end
                    wr(A_STAT, 32'h30);
                    peek(A_STAT, d); chk("R9 w1c clears causes", d, mk_stat(tail, 0, 0, 0));
                    chk("R10 irq low when clear", {31'h0, irq}, 0);
                end
            end
        end

        // R8 failure with error enable off raises nothing
        do_reset();
        wr(A_SIZE, 3);
        wr(A_CTRL, mk_ctrl(8'h1, 1'b0, 1'b1));
        serve("R8 masked", 8'h0, 8'h08, 8'h00, 0);
        peek(A_STAT, d); chk("R8 no error cause when disabled", d, mk_stat(8'h1, 0, 0, 0));
        chk("R8 irq low", {31'h0, irq}, 0);

        // R13 back-to-back batch, then across the wrap
        do_reset();
        wr(A_SIZE, 3);
        wr(A_CTRL, mk_ctrl(8'h3, 1'b1, 1'b1));
        serve("R13 batch", 8'h0, 8'h01, 8'h00, 0);
        serve("R13 batch", 8'h1, 8'h01, 8'h00, 0);
        serve("R13 batch", 8'h2, 8'h01, 8'h00, 0);
        peek(A_STAT, d); chk("R13 caught up", d, mk_stat(8'h3, 0, 0, 0));
        wr(A_CTRL, mk_ctrl(8'h1, 1'b1, 1'b1));
        serve("R13 wrap", 8'h3, 8'h01, 8'h00, 0);
        serve("R13 wrap", 8'h0, 8'h01, 8'h00, 0);
        peek(A_STAT, d); chk("R13 tail after wrap", d, mk_stat(8'h1, 0, 0, 0));

        // R5 completion pulse while idle is ignored
        @(negedge clk);
        done_valid = 1'b1; done_status = 8'h08; done_ctrl = 8'h40;
        #1 chk("R5 no writeback when idle", {31'h0, wb_valid}, 0);
        @(negedge clk);
        done_valid = 1'b0;
        peek(A_STAT, d); chk("R5 idle pulse changes nothing", d, mk_stat(8'h1, 0, 0, 0));
        chk("R5 idle pulse no irq", {31'h0, irq}, 0);

        // R11 stop on failure halts with work pending
        do_reset();
        wr(A_SIZE, 3);
        wr(A_CTRL, mk_ctrl(8'h2, 1'b1, 1'b1));
        serve("R11 failing slot", 8'h0, 8'h08, 8'hC0, 0);
        no_issue("R11 halted keeps pending slot", 8);
        peek(A_STAT, d); chk("R11 stat after halt", d, mk_stat(8'h1, 1, 1, 0));
        wr(A_CTRL, mk_ctrl(8'h2, 1'b1, 1'b0));
        no_issue("R11 still halted with run off", 3);
        wr(A_CTRL, mk_ctrl(8'h2, 1'b1, 1'b1));
        serve("R11 resume", 8'h1, 8'h01, 8'h00, 0);

        // R12 run bit cleared while a slot is outstanding
        do_reset();
        wr(A_SIZE, 3);
        wr(A_CTRL, mk_ctrl(8'h2, 1'b0, 1'b1));
        wait_issue("R12 first", 8'h0);
        give_ready(0);
        wr(A_CTRL, mk_ctrl(8'h2, 1'b0, 1'b0));
        give_done("R12 outstanding completes", 8'h0, 8'h01, 8'h00);
        no_issue("R12 no new hand-off", 8);
        peek(A_STAT, d); chk("R12 tail advanced once", d, mk_stat(8'h1, 0, 0, 0));
        peek(A_CTRL, d); chk("R12 head untouched", d, mk_ctrl(8'h2, 0, 0));
        wr(A_CTRL, mk_ctrl(8'h2, 1'b0, 1'b1));
        serve("R12 restart", 8'h1, 8'h01, 8'h00, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule